// File: doc/BRIEF.md
# Two-Phase Machine Clock and Memory-Cycle Sequencer

This block derives a slow machine clock from a fast system clock. A free-running oscillator divider produces two complementary phase signals, A and B, each lasting a fixed number of system clocks. An eight-state one-hot counter, T0 to T7, steps once per machine cycle. Each state spans one phase A and phase B pair, so eight states make one memory cycle. Downstream logic reads the phases and the T-states as levels, not as clocks.

The counter advances on an advance pulse. That pulse is decoded one system clock before the oscillator turns from phase B to phase A, so the new T-state and the rise of phase A appear on the same system clock edge. While an arithmetic or shift operation still needs cycles, a hold input keeps the counter in T7 for one more machine cycle at a time. In single-step mode a console key replaces the oscillator. With run and single-step both off, the counter is frozen. A one-clock pulse marks each entry into T0.

Top module: `tclk_sequencer`

## Requirements
- R1: In run mode, phase A is high for 7 system clocks and then low for 7 system clocks, repeating. Phase B is always the complement of phase A.
- R2: The T-state output is one-hot, with bit n standing for Tn. In run mode it steps T0, T1, ..., T7 and wraps back to T0, taking one step per machine cycle.
- R3: In run mode the advance output is high for exactly the one system clock before phase A rises. The T-state changes on the same edge on which phase A rises.
- R4: While the T-state is T7 and either the arithmetic-hold or the shift-hold input is high, no advance occurs and T7 repeats. In any other state, neither hold input has an effect. If the hold drops in the clock where the advance is due, the advance happens on that edge.
- R5: In single-step mode (run low, single-step high), phase A equals the key input delayed by one system clock. Each rising key press advances the T-state once, on the same edge on which phase A rises.
- R6: With run and single-step both low, the T-state does not change, phase A is low and phase B is high.
- R7: The T0 pulse is high for exactly one system clock: the first clock in which the counter holds T0 after leaving T7.
- R8: While the synchronous active-low reset is asserted, the block goes to T7 with phase B active, the advance output low and the T0 pulse low. The oscillator restarts at the start of its low half.
- R9: At every clock after reset, exactly one bit of the T-state output is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Processor running; the oscillator drives the phases and the advance (has priority over single-step) |
| step_mode_i | input | 1 | Single-step mode; the key drives the phases and the advance |
| key_i | input | 1 | Start key, high while pressed |
| arith_hold_i | input | 1 | Arithmetic still needs cycles; holds T7 |
| shift_hold_i | input | 1 | Shift still needs cycles; holds T7 |
| phase_a_o | output | 1 | Phase A |
| phase_b_o | output | 1 | Phase B, the complement of phase A |
| t_state_o | output | 8 | One-hot T-state, bit n = Tn |
| advance_o | output | 1 | Effective advance pulse, high in the clock before the T-state changes |
| t0_pulse_o | output | 1 | One-clock marker at the start of T0 |

## Verification
The interaction that matters most is a hold release landing in the same system clock as the early advance decode. The bench waits in a held T7 until the oscillator reaches the last clock of phase B and drops the hold right there. It then expects the advance output to rise within that same clock, followed by T0, the T0 pulse and the rise of phase A on the next edge. A hold raised in states other than T7, and key presses with the processor stopped, are judged against a behavioural model that is compared on every clock.

// File: rtl/tclk_pkg.sv
// Package: shared types and helpers for the machine clock sequencer.
// Assumes: only run/step/stop source selection needs a shared type.
package tclk_pkg;

    // Which source drives phases and advance
    typedef enum logic [1:0] {
        SRC_STOP = 2'd0,
        SRC_RUN  = 2'd1,
        SRC_STEP = 2'd2
    } clk_src_e;

    // Run has priority over single-step; neither means stopped
    function automatic clk_src_e pick_src(input logic run, input logic step);
        if (run)       return SRC_RUN;
        else if (step) return SRC_STEP;
        else           return SRC_STOP;
    endfunction

endpackage

// File: rtl/tclk_osc.sv
// Module: free-running oscillator divider.
// Produces a high half and a low half of HALF_CLKS system clocks each,
// plus an early flag in the last clock of the low half (one clock before
// the high half starts). Assumes HALF_CLKS >= 2. Reset starts the low half.
module tclk_osc #(
    parameter int HALF_CLKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    output logic osc_high_o,
    output logic early_o
);
    localparam int PERIOD = 2 * HALF_CLKS;
    localparam int CW     = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] START = CW'(HALF_CLKS);

    logic [CW-1:0] cnt_q;

    // Position counter within the machine cycle, wraps at PERIOD
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= START;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // Decode high half and the pre-rise clock
    always_comb begin
        osc_high_o = (cnt_q < START);
        early_o    = (cnt_q == LAST);
    end

    // R1: the clock after the early flag is always the first high clock
    // R1
    early_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_o |=> (osc_high_o && cnt_q == '0));

endmodule

// File: rtl/tclk_key.sv
// Module: start-key registration for single-step mode.
// Registers the key once (the key is assumed already debounced and
// synchronous) and flags the clock in which a press first appears.
module tclk_key (
    input  logic clk,
    input  logic rst_n,
    input  logic key_i,
    output logic key_q_o,
    output logic press_o
);
    logic key_q;

    // Hold last sampled key level
    always_ff @(posedge clk) begin
        if (!rst_n) key_q <= 1'b0;
        else        key_q <= key_i;
    end

    // Press is seen before it registers, so the state change meets phase A
    always_comb begin
        key_q_o = key_q;
        press_o = key_i && !key_q;
    end

endmodule

// File: rtl/tclk_ring.sv
// Module: one-hot T-state ring with T0 marker.
// Shifts the single set bit up by one on each advance, wrapping from the
// last state to state 0. Reset parks it in the last state. Assumes the
// advance input already carries all blocking conditions.
module tclk_ring #(
    parameter int N_STATES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_i,
    output logic [N_STATES-1:0] state_o,
    output logic                t0_pulse_o
);
    localparam int LASTI = N_STATES - 1;

    logic [N_STATES-1:0] st_q;
    logic [N_STATES-1:0] st_d;
    logic                t0_q;

    // Next-state per bit: take the lower neighbour on advance
    for (genvar i = 0; i < N_STATES; i++) begin : g_bit
        localparam int PREV = (i == 0) ? LASTI : i - 1;
        always_comb st_d[i] = adv_i ? st_q[PREV] : st_q[i];
    end

    // State register, reset to the last state
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= N_STATES'(1) << LASTI;
        else        st_q <= st_d;
    end

    // Mark the first clock of state 0 after a wrap
    always_ff @(posedge clk) begin
        if (!rst_n) t0_q <= 1'b0;
        else        t0_q <= adv_i && st_q[LASTI];
    end

    assign state_o    = st_q;
    assign t0_pulse_o = t0_q;

    // R9
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q) == 1);

    // R7
    t0_marks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t0_q |-> (st_q[0] && $past(st_q[LASTI])));

endmodule

// File: rtl/tclk_sequencer.sv
// Module: two-phase machine clock and T-state sequencer (top).
// Selects the phase and advance source (oscillator, start key or none),
// blocks the wrap out of the last T-state while a hold is active, and
// drives the one-hot ring. Assumes mode and hold inputs are synchronous.
module tclk_sequencer
    import tclk_pkg::*;
#(
    parameter int HALF_CLKS = 7,
    parameter int N_STATES  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                step_mode_i,
    input  logic                key_i,
    input  logic                arith_hold_i,
    input  logic                shift_hold_i,
    output logic                phase_a_o,
    output logic                phase_b_o,
    output logic [N_STATES-1:0] t_state_o,
    output logic                advance_o,
    output logic                t0_pulse_o
);
    localparam int LASTI = N_STATES - 1;

    clk_src_e            src;
    logic                osc_high;
    logic                early;
    logic                key_q;
    logic                press;
    logic                adv_raw;
    logic                adv;
    logic                hold;
    logic                phase_a;
    logic [N_STATES-1:0] st;
    logic                t0p;

    tclk_osc #(.HALF_CLKS(HALF_CLKS)) i_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_high_o(osc_high),
        .early_o   (early)
    );

    tclk_key i_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_i  (key_i),
        .key_q_o(key_q),
        .press_o(press)
    );

    // Pick source, then form phase and raw advance from it
    always_comb begin
        src = pick_src(run_i, step_mode_i);
        unique case (src)
            SRC_RUN: begin
                phase_a = osc_high;
                adv_raw = early;
            end
            SRC_STEP: begin
                phase_a = key_q;
                adv_raw = press;
            end
            default: begin
                phase_a = 1'b0;
                adv_raw = 1'b0;
            end
        endcase
    end

    // Block the wrap out of the last state while arithmetic or shift runs
    always_comb begin
        hold = arith_hold_i || shift_hold_i;
        adv  = adv_raw && !(st[LASTI] && hold);
    end

    tclk_ring #(.N_STATES(N_STATES)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv),
        .state_o   (st),
        .t0_pulse_o(t0p)
    );

    assign phase_a_o  = phase_a;
    assign phase_b_o  = !phase_a;
    assign t_state_o  = st;
    assign advance_o  = adv;
    assign t0_pulse_o = t0p;

    // R3
    state_meets_phase_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && st != $past(st)) |-> (phase_a && !$past(phase_a)));

    // R4
    hold_keeps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st[LASTI] && (arith_hold_i || shift_hold_i)) |=> st[LASTI]);

    // R6
    stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !step_mode_i) |=> $stable(st));

endmodule

// File: tb/test_tclk_sequencer.sv
module test_tclk_sequencer;
    localparam int CLK_PERIOD = 20;
    localparam int HALF = 7;
    localparam int PER = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0, step_mode_i = 1'b0, key_i = 1'b0;
    logic       arith_hold_i = 1'b0, shift_hold_i = 1'b0;
    logic       phase_a_o, phase_b_o, advance_o, t0_pulse_o;
    logic [7:0] t_state_o;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int m_cnt = HALF;
    int m_t = 7;
    bit m_key = 0;
    bit m_t0 = 0;

    tclk_sequencer i_tclk_sequencer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .step_mode_i(step_mode_i),
        .key_i(key_i), .arith_hold_i(arith_hold_i), .shift_hold_i(shift_hold_i),
        .phase_a_o(phase_a_o), .phase_b_o(phase_b_o), .t_state_o(t_state_o),
        .advance_o(advance_o), .t0_pulse_o(t0_pulse_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_adv();
        bit raw;
        if (run_i)            raw = (m_cnt == PER - 1);
        else if (step_mode_i) raw = key_i && !m_key;
        else                  raw = 0;
        return raw && !(m_t == 7 && (arith_hold_i || shift_hold_i));
    endfunction

    function automatic bit m_pha();
        if (run_i)            return m_cnt < HALF;
        else if (step_mode_i) return m_key;
        else                  return 0;
    endfunction

    // Reference model update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = HALF; m_t = 7; m_key = 0; m_t0 = 0;
        end else begin
            bit a;
            a = m_adv();
            m_t0 = a && (m_t == 7);
            if (a) m_t = (m_t + 1) % 8;
            m_cnt = (m_cnt + 1) % PER;
            m_key = key_i;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model
    task automatic compare();
        string ptag;
        ptag = run_i ? "R1" : (step_mode_i ? "R5" : "R6");
        chk(ptag, 32'(phase_a_o), 32'(m_pha()));
        chk("R1", 32'(phase_b_o), 32'(!phase_a_o));
        chk("R2", 32'(t_state_o), 32'(8'(1) << m_t));
        chk("R3", 32'(advance_o), 32'(m_adv()));
        chk("R7", 32'(t0_pulse_o), 32'(m_t0));
        chk("R9", 32'($countones(t_state_o)), 32'd1);
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        ticks(4);
        // R8 reset state
        chk("R8", 32'(t_state_o), 32'h80);
        chk("R8", 32'(phase_b_o), 32'd1);
        chk("R8", 32'(advance_o), 32'd0);
        chk("R8", 32'(t0_pulse_o), 32'd0);
        rst_n = 1'b1;
        ticks(3);
        // R6 stopped: nothing moves
        ticks(40);
        chk("R6", 32'(t_state_o), 32'h80);
        run_i = 1'b1;
        ticks(PER * 20);
        // R4 hold outside T7 has no effect
        while (m_t != 3) tick();
        arith_hold_i = 1'b1;
        ticks(PER * 2);
        chk("R4", 32'(t_state_o), 32'h20);
        while (m_t != 7) tick();
        ticks(PER * 4);
        chk("R4", 32'(t_state_o), 32'h80);
        // R4 release in the clock of the early decode
        while (m_cnt != PER - 1) tick();
        arith_hold_i = 1'b0;
        #1;
        chk("R4", 32'(advance_o), 32'd1);
        tick();
        chk("R7", 32'(t0_pulse_o), 32'd1);
        chk("R3", 32'(phase_a_o), 32'd1);
        // Shift hold
        while (m_t != 7) tick();
        shift_hold_i = 1'b1;
        ticks(PER * 3 + 5);
        chk("R4", 32'(t_state_o), 32'h80);
        shift_hold_i = 1'b0;
        ticks(PER * 10);
        // R5 single-step with key presses of varied length
        run_i = 1'b0; step_mode_i = 1'b1;
        ticks(3);
        for (int k = 0; k < 12; k++) begin
            key_i = 1'b1;
            ticks(2 + (k % 4));
            key_i = 1'b0;
            ticks(3 + (k % 3));
        end
        key_i = 1'b1; arith_hold_i = 1'b1;
        ticks(5);
        key_i = 1'b0; arith_hold_i = 1'b0;
        ticks(5);
        // R6 stopped with key activity ignored
        step_mode_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            key_i = 1'b1; ticks(4); key_i = 1'b0; ticks(4);
        end
        chk("R6", 32'(phase_a_o), 32'd0);
        run_i = 1'b1;
        ticks(PER * 10);
        summary();
    end
endmodule